// File: doc/BRIEF.md
# Cascaded Interrupt Aggregator

This block collects twenty-four interrupt request lines into three byte-wide banks. Each bank is seen by software as two byte registers: a status byte that shows which sources have fired, and an enable byte that chooses which of them may reach the host. Every request line passes through a two-flop synchronizer. A rising edge on an edge-type line is stored in a pending latch only when that line is enabled at that moment. One configurable source is level-type: its status bit shows the synchronized input level directly and nothing is latched for it.

Software finds out which sources fired by reading the status bytes. A status read returns the bits and, in the same clock, clears the edge latches that were set at that moment. No separate acknowledge register exists. The host sees a single cascade request line. It is high while any enabled status bit is set, so each new event after a full clear gives the host a fresh rising edge.

The cascade line is driven by a two-state machine. QUIET moves to RAISED on the clock after the combined enabled-status vector becomes nonzero. RAISED moves back to QUIET on the clock after that vector becomes zero. In every other case the state does not change.

Top module: `cascade_irq_agg`

## Requirements
- R1: Byte addresses decode as follows: 0 status bank A (sources 0–7), 1 enable bank A, 2 status bank B (sources 8–15), 3 enable bank B, 4 status bank C (sources 16–23), 5 enable bank C. Source n appears at bit n mod 8. Reads of addresses 6 and 7 return 0.
- R2: After reset, all enable bytes and all latches are 0, and the cascade line and read data are 0. Writing 0 to all three enable bytes disables every source, and the cascade line is then 0 two clocks later.
- R3: A write stores its byte into the addressed enable register at the clock edge. An enable bit of 1 lets its source through and a 0 blocks it. A later read returns the stored byte.
- R4: Each input is synchronized through two flops. A rising edge, meaning the synchronized value is 1 now and was 0 one clock earlier, on an enabled edge-type input sets its latch three clock edges after the input changes.
- R5: A rising edge on an input whose enable bit is 0 at that moment is dropped. Setting the enable bit afterwards does not make it appear.
- R6: A status read returns the bits as they were before the clock edge and clears exactly the latches that were set then. An edge captured at the same edge stays latched and is returned by the next read.
- R7: The level-type source (source 11 by default) shows its synchronized input level in its status bit. A read does not clear it. It drives the cascade line only while its enable bit is 1.
- R8: The cascade line is a register that equals the OR of (status AND enable) over all 24 bits as they were one clock earlier. After a read clears the last pending bit, it falls.
- R9: Read data appears on the clock after a cycle with read strobe set, and is 0 after cycles without one. Writes to status addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 24 | Asynchronous interrupt request lines |
| bus_addr | input | 3 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data byte |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| cascade_irq | output | 1 | Aggregated request toward the host |

## Verification
The hardest case to produce from the ports is an edge that is captured at the same clock edge at which its bank's status is read. This is the case where a careless clear would lose the new bit. The stimulus raises a second source exactly two clocks before it issues a status read, so the edge-detect window lines up with the read. It then expects the old bit on the first read and the new bit on the second. A behavioural model that runs alongside the design checks read data and the cascade line on every clock. This covers both directed sequences and a long random mix of toggles, reads and writes.

// File: rtl/agg_pkg.sv
package agg_pkg;

    typedef enum logic {
        CASC_QUIET  = 1'b0,
        CASC_RAISED = 1'b1
    } casc_state_e;

endpackage

// File: rtl/agg_sync_edge.sv
module agg_sync_edge #(
    parameter int unsigned WIDTH  = 24,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] sync_q,
    output logic [WIDTH-1:0] rise
);

    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
            prev_q <= '0;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
            prev_q <= stage_q[LAST];
        end
    end

    assign sync_q = stage_q[LAST];
    assign rise   = stage_q[LAST] & ~prev_q;

endmodule

// File: rtl/agg_bank.sv
module agg_bank #(
    parameter int unsigned     WIDTH      = 8,
    parameter logic [WIDTH-1:0] LEVEL_BITS = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_lvl,
    input  logic [WIDTH-1:0] rise,
    input  logic             enable_we,
    input  logic [WIDTH-1:0] wdata,
    input  logic             status_rd,
    output logic [WIDTH-1:0] status,
    output logic [WIDTH-1:0] enable_q,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] pending
);

    logic [WIDTH-1:0] kept;
    logic [WIDTH-1:0] capture;

    // bits present before this edge are dropped by a status read
    assign kept    = status_rd ? '0 : latch_q;
    assign capture = rise & enable_q & ~LEVEL_BITS;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q  <= '0;
            enable_q <= '0;
        end else begin
            latch_q <= kept | capture;
            if (enable_we) begin
                enable_q <= wdata;
            end
        end
    end

    assign status  = (latch_q & ~LEVEL_BITS) | (sync_lvl & LEVEL_BITS);
    assign pending = status & enable_q;

endmodule

// File: rtl/agg_cascade_fsm.sv
module agg_cascade_fsm
    import agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_pending,
    output logic cascade
);

    casc_state_e state_q;
    casc_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CASC_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CASC_QUIET:  if (any_pending)  state_d = CASC_RAISED;
            CASC_RAISED: if (!any_pending) state_d = CASC_QUIET;
            default:     state_d = CASC_QUIET;
        endcase
    end

    always_comb begin
        cascade = (state_q == CASC_RAISED);
    end

endmodule

// File: rtl/cascade_irq_agg.sv
module cascade_irq_agg #(
    parameter int unsigned BANK_W      = 8,
    parameter int unsigned NUM_BANKS   = 3,
    parameter int unsigned LEVEL_SRC   = 11,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned NUM_SRC    = BANK_W * NUM_BANKS,
    localparam int unsigned ADDR_W     = $clog2(2 * NUM_BANKS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [BANK_W-1:0]  bus_wdata,
    input  logic               bus_rd,
    output logic [BANK_W-1:0]  bus_rdata,
    output logic               cascade_irq
);

    localparam logic [ADDR_W-1:0] ADDR_LIMIT = ADDR_W'(2 * NUM_BANKS);

    logic [NUM_SRC-1:0] sync_lvl;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] mask_all;
    logic [NUM_SRC-1:0] latch_all;
    logic [NUM_SRC-1:0] pend_all;
    logic [BANK_W-1:0]  status_b [NUM_BANKS];
    logic [BANK_W-1:0]  enable_b [NUM_BANKS];
    logic [ADDR_W-1:0]  sel_bank;
    logic               addr_hit;
    logic               pick_enable;
    logic               pend_any;
    logic [BANK_W-1:0]  rd_val;

    assign sel_bank    = bus_addr >> 1;
    assign addr_hit    = bus_addr < ADDR_LIMIT;
    assign pick_enable = bus_addr[0];

    agg_sync_edge #(
        .WIDTH (NUM_SRC),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (irq_in),
        .sync_q(sync_lvl),
        .rise  (rise)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [BANK_W-1:0] LV =
            ((LEVEL_SRC / BANK_W) == b) ? (BANK_W'(1) << (LEVEL_SRC % BANK_W)) : '0;
        logic hit_b;
        assign hit_b = addr_hit && (sel_bank == ADDR_W'(b));

        agg_bank #(
            .WIDTH     (BANK_W),
            .LEVEL_BITS(LV)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_lvl (sync_lvl[b*BANK_W +: BANK_W]),
            .rise     (rise[b*BANK_W +: BANK_W]),
            .enable_we(bus_wr && hit_b && pick_enable),
            .wdata    (bus_wdata),
            .status_rd(bus_rd && hit_b && !pick_enable),
            .status   (status_b[b]),
            .enable_q (enable_b[b]),
            .latch_q  (latch_all[b*BANK_W +: BANK_W]),
            .pending  (pend_all[b*BANK_W +: BANK_W])
        );

        assign mask_all[b*BANK_W +: BANK_W] = enable_b[b];
    end

    assign pend_any = |pend_all;

    always_comb begin
        rd_val = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr_hit && sel_bank == ADDR_W'(b)) begin
                rd_val = pick_enable ? enable_b[b] : status_b[b];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= bus_rd ? rd_val : '0;
        end
    end

    agg_cascade_fsm u_casc (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_pending(pend_any),
        .cascade    (cascade_irq)
    );

endmodule

// File: rtl/agg_checker.sv
module agg_checker #(
    parameter int unsigned BANK_W    = 8,
    parameter int unsigned NUM_BANKS = 3,
    parameter int unsigned NUM_SRC   = 24,
    parameter int unsigned ADDR_W    = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [BANK_W-1:0]  bus_wdata,
    input logic               bus_rd,
    input logic [BANK_W-1:0]  bus_rdata,
    input logic               cascade_irq,
    input logic               pend_any,
    input logic [NUM_SRC-1:0] mask_all,
    input logic [NUM_SRC-1:0] latch_all
);

    AST_RESET_MASK_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (mask_all == '0 && latch_all == '0)); // R2

    AST_MASK_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(1)) |=> (mask_all[BANK_W-1:0] == $past(bus_wdata))); // R3

    AST_NO_MASKED_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ((latch_all & ~$past(latch_all) & ~$past(mask_all)) == '0)); // R5

    AST_CASCADE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        pend_any |=> cascade_irq); // R8

    AST_CASCADE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_any |=> !cascade_irq); // R8

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0)); // R9

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_clr
        AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && bus_addr == ADDR_W'(2 * b))
            |=> ((latch_all[b*BANK_W +: BANK_W] & $past(latch_all[b*BANK_W +: BANK_W])) == '0)); // R6
    end

endmodule

bind cascade_irq_agg agg_checker #(
    .BANK_W   (BANK_W),
    .NUM_BANKS(NUM_BANKS),
    .NUM_SRC  (NUM_SRC),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .cascade_irq(cascade_irq),
    .pend_any   (pend_any),
    .mask_all   (mask_all),
    .latch_all  (latch_all)
);

// File: tb/sim_cascade_irq_agg.sv
`timescale 1ns/1ps
module sim_cascade_irq_agg;

    localparam logic [23:0] LV = 24'h000800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] irq_in = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        cascade_irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cascade_irq_agg u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .cascade_irq(cascade_irq)
    );

    // behavioural reference
    logic [23:0] m_s1, m_s2, m_prev, m_latch, m_mask;
    logic [7:0]  e_rd;
    logic        e_cas;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_latch = '0; m_mask = '0;
            e_rd = '0; e_cas = 1'b0;
        end else begin
            logic [23:0] st, edg, clr;
            logic [7:0]  rv;
            int bk;
            st  = (m_latch & ~LV) | (m_s2 & LV);
            edg = m_s2 & ~m_prev;
            bk  = int'(bus_addr) / 2;
            rv  = '0;
            clr = '0;
            if (bus_rd && bus_addr < 3'd6) begin
                rv = bus_addr[0] ? m_mask[bk*8 +: 8] : st[bk*8 +: 8];
                if (!bus_addr[0]) clr[bk*8 +: 8] = 8'hFF;
            end
            e_cas   = |(st & m_mask);
            e_rd    = rv;
            m_latch = (m_latch & ~clr) | (edg & m_mask & ~LV);
            if (bus_wr && bus_addr < 3'd6 && bus_addr[0]) m_mask[bk*8 +: 8] = bus_wdata;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = irq_in;
        end
        #1;
        chk(bus_rdata == e_rd, "R9 rdata vs model", bus_rdata, e_rd);
        chk(cascade_irq == e_cas, "R8 cascade vs model", cascade_irq, e_cas);
    end

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        logic [7:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        chk(cascade_irq == 1'b0, "R2 cascade after reset", cascade_irq, 0);
        do_read(3'd1, v); chk(v == 8'h00, "R2 enable A after reset", v, 0);

        do_write(3'd1, 8'hA5);
        do_read(3'd1, v); chk(v == 8'hA5, "R3 enable A readback", v, 8'hA5);
        do_write(3'd3, 8'hFF);
        do_write(3'd5, 8'h0F);

        // R5: edge on disabled source 1
        @(negedge clk); irq_in[1] = 1'b1;
        idle(6);
        do_read(3'd0, v); chk(v == 8'h00, "R5 masked edge dropped", v, 0);
        do_write(3'd1, 8'hA7);
        idle(6);
        do_read(3'd0, v); chk(v == 8'h00, "R5 unmask does not revive", v, 0);
        chk(cascade_irq == 1'b0, "R5 cascade stays low", cascade_irq, 0);

        // R4 / R6 / R8: enabled edge on source 0
        @(negedge clk); irq_in[0] = 1'b1;
        idle(6);
        chk(cascade_irq == 1'b1, "R8 cascade high on pending", cascade_irq, 1);
        do_read(3'd0, v); chk(v == 8'h01, "R4 edge latched", v, 8'h01);
        do_read(3'd0, v); chk(v == 8'h00, "R6 cleared by read", v, 0);
        chk(cascade_irq == 1'b0, "R8 cascade falls after clear", cascade_irq, 0);

        // R9: status write ignored
        do_write(3'd0, 8'hFF);
        do_read(3'd0, v); chk(v == 8'h00, "R9 status write ignored", v, 0);

        // R7: level source 11
        @(negedge clk); irq_in[11] = 1'b1;
        idle(6);
        chk(cascade_irq == 1'b1, "R7 level raises cascade", cascade_irq, 1);
        do_read(3'd2, v); chk(v == 8'h08, "R7 level status", v, 8'h08);
        do_read(3'd2, v); chk(v == 8'h08, "R7 level not cleared", v, 8'h08);
        do_write(3'd3, 8'hF7);
        idle(2);
        chk(cascade_irq == 1'b0, "R7 disabled level gated", cascade_irq, 0);
        do_read(3'd2, v); chk(v == 8'h08, "R7 status shows level when disabled", v, 8'h08);
        irq_in[11] = 1'b0;
        idle(4);
        do_read(3'd2, v); chk(v == 8'h00, "R7 status follows level low", v, 0);

        // R6: edge captured on the same edge as the read
        @(negedge clk); irq_in[16] = 1'b1;
        idle(6);
        irq_in[17] = 1'b1;
        @(negedge clk);
        do_read(3'd4, v); chk(v == 8'h01, "R6 first read old bit", v, 8'h01);
        do_read(3'd4, v); chk(v == 8'h02, "R6 same-cycle edge kept", v, 8'h02);

        // R1: map and bit placement across banks
        do_write(3'd5, 8'h1F);
        @(negedge clk); irq_in[2] = 1'b1; irq_in[8] = 1'b1; irq_in[20] = 1'b1;
        idle(6);
        do_read(3'd0, v); chk(v == 8'h04, "R1 bank A bit 2", v, 8'h04);
        do_read(3'd2, v); chk(v == 8'h01, "R1 bank B bit 0", v, 8'h01);
        do_read(3'd4, v); chk(v == 8'h10, "R1 bank C bit 4", v, 8'h10);
        do_read(3'd6, v); chk(v == 8'h00, "R1 unmapped address", v, 0);
        do_read(3'd3, v); chk(v == 8'hF7, "R1 enable B address", v, 8'hF7);
        do_read(3'd5, v); chk(v == 8'h1F, "R1 enable C address", v, 8'h1F);

        // random mix, checked against the model every clock
        @(negedge clk); irq_in = '0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            bus_rd = 1'b0; bus_wr = 1'b0;
            if ($urandom_range(0, 2) == 0) irq_in = irq_in ^ (24'(1) << $urandom_range(0, 23));
            if ($urandom_range(0, 3) == 0) begin
                bus_rd = 1'b1; bus_addr = 3'($urandom_range(0, 7));
            end else if ($urandom_range(0, 9) == 0) begin
                bus_wr = 1'b1; bus_addr = 3'($urandom_range(0, 7));
                bus_wdata = 8'($urandom);
            end
        end
        @(negedge clk); bus_rd = 1'b0; bus_wr = 1'b0;

        // R2: all enables written to 0
        do_write(3'd1, 8'h00);
        do_write(3'd3, 8'h00);
        do_write(3'd5, 8'h00);
        idle(2);
        chk(cascade_irq == 1'b0, "R2 all disabled cascade low", cascade_irq, 0);
        do_read(3'd5, v); chk(v == 8'h00, "R2 enable C zero", v, 0);
        idle(2);
        summary();
    end

endmodule